// File: doc/BRIEF.md
# Local bus interrupt controller

The block collects sixteen level-sensitive interrupt lines from local bus devices into a source register and qualifies them with a software-controlled enable mask. A single combined request goes to the processor whenever at least one enabled line is active.

Software reaches the block through a 16-bit register port. One offset returns an encoded vector that identifies the enabled active line with the lowest index, so the handler can dispatch straight from it. A second offset holds the enable mask, which can be read and written. All other offsets read as zero and ignore writes. Lines are level-based only: a device keeps its line high until serviced, and the source bit follows it. The block does no edge capture or latching.

Top module: `lbic_top`

## Requirements
- R1: Source bit i takes the level of `irq_i[i]` at every rising clock edge; a line that drops clears its bit, with no latching.
- R2: `irq_o` is high exactly when the source register ANDed with the enable mask is non-zero.
- R3: A read at byte offset 0x000 returns (i+1)*4, where i is the lowest-numbered bit that is both active and enabled; it returns 0 when no such bit exists (line 0 gives 0x0004, line 15 gives 0x0040).
- R4: Byte offset 0x002 holds the enable mask (bit i enables line i); a write there takes effect on the next clock edge and a read returns the stored value.
- R5: While `rst_ni` is low the enable mask is 0x0010, the source register is 0 and `irq_o` is 0.
- R6: Reads at any offset other than 0x000 and 0x002 return 0; writes there, and writes to offset 0x000, change no state.
- R7: `irq_o` is a register output: a change of an input level or of the mask appears on `irq_o` at the first rising edge after it, and not before.
- R8: Reading the vector changes neither the source bits nor `irq_o`; repeated reads return the same value.
- R9: `rdata_o` is 0 in any cycle without a read access (`req_i` low, or `we_i` high).

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Interrupt request levels, one per line |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | Access is a write when high |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The hardest case to reach is a mask write and a change of line levels landing on the same clock edge. The combined output must then reflect the new mask and the new levels together, not a mix of old and new. The stimulus table has rows that write a new mask in the same cycle that a new input pattern is applied. Other rows hold several lines active at once, so the vector has to pick the lowest index and not the highest. Directed steps then watch `irq_o` just before and just after the edge, to pin down the one-cycle latency.

// File: rtl/lbic_pkg.sv
package lbic_pkg;
  localparam int unsigned LBIC_VEC_OFS  = 0;
  localparam int unsigned LBIC_MASK_OFS = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_VEC,
    SEL_MASK
  } lbic_sel_e;
endpackage

// File: rtl/lbic_src_reg.sv
module lbic_src_reg #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] lvl_i,
  output logic [N_SRC-1:0] src_o
);
  logic [N_SRC-1:0] src_q;

  // level tracking only: no sticky bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= lvl_i;
  end

  assign src_o = src_q;
endmodule

// File: rtl/lbic_prio_enc.sv
module lbic_prio_enc #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic [N_SRC-1:0]  pend_i,
  output logic [DATA_W-1:0] vec_o
);
  logic [N_SRC:0]   seen;
  logic [N_SRC-1:0] hit;

  assign seen[0] = 1'b0;

  // lowest index wins: a line hits only if nothing below it is pending
  for (genvar g = 0; g < N_SRC; g++) begin : g_chain
    assign hit[g]      = pend_i[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | pend_i[g];
  end

  always_comb begin
    vec_o = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (hit[k]) vec_o = DATA_W'((k + 1) * 4);
    end
  end
endmodule

// File: rtl/lbic_regif.sv
module lbic_regif
  import lbic_pkg::*;
#(
  parameter int unsigned        N_SRC    = 16,
  parameter int unsigned        DATA_W   = 16,
  parameter int unsigned        ADDR_W   = 12,
  parameter logic [N_SRC-1:0]   MASK_RST = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  lvl_i,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [DATA_W-1:0] vec_i,
  output logic [N_SRC-1:0]  pend_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  lbic_sel_e        sel;
  logic             wr_mask;
  logic [N_SRC-1:0] mask_q, mask_nxt;
  logic             irq_q;

  always_comb begin
    if (addr_i == ADDR_W'(LBIC_VEC_OFS))       sel = SEL_VEC;
    else if (addr_i == ADDR_W'(LBIC_MASK_OFS)) sel = SEL_MASK;
    else                                       sel = SEL_NONE;
  end

  assign wr_mask  = req_i & we_i & (sel == SEL_MASK);
  assign mask_nxt = wr_mask ? wdata_i[N_SRC-1:0] : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= MASK_RST;
    else         mask_q <= mask_nxt;
  end

  // look ahead to next-state source and mask so irq_o lines up with them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(lvl_i & mask_nxt);
  end

  assign pend_o = src_i & mask_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (sel)
        SEL_VEC:  rdata_o = vec_i;
        SEL_MASK: rdata_o = DATA_W'(mask_q);
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lbic_top.sv
module lbic_top #(
  parameter int unsigned      N_SRC    = 16,
  parameter int unsigned      DATA_W   = 16,
  parameter int unsigned      ADDR_W   = 12,
  parameter logic [N_SRC-1:0] MASK_RST = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0]  src_q;
  logic [N_SRC-1:0]  pend;
  logic [N_SRC-1:0]  mask_q;
  logic [DATA_W-1:0] vec;

  lbic_src_reg #(.N_SRC(N_SRC)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (irq_i),
    .src_o  (src_q)
  );

  lbic_prio_enc #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_enc (
    .pend_i (pend),
    .vec_o  (vec)
  );

  lbic_regif #(
    .N_SRC    (N_SRC),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MASK_RST (MASK_RST)
  ) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .lvl_i   (irq_i),
    .src_i   (src_q),
    .vec_i   (vec),
    .pend_o  (pend),
    .mask_o  (mask_q),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/lbic_top_chk.sv
module lbic_top_chk
  import lbic_pkg::*;
#(
  parameter int unsigned      N_SRC    = 16,
  parameter int unsigned      DATA_W   = 16,
  parameter int unsigned      ADDR_W   = 12,
  parameter logic [N_SRC-1:0] MASK_RST = 16'h0010
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  irq_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  mask_q
);
  logic rd_vec, rd_mask, rd_other, wr_mask;
  assign rd_vec   = req_i && !we_i && addr_i == ADDR_W'(LBIC_VEC_OFS);
  assign rd_mask  = req_i && !we_i && addr_i == ADDR_W'(LBIC_MASK_OFS);
  assign rd_other = req_i && !we_i && !rd_vec && !rd_mask;
  assign wr_mask  = req_i && we_i && addr_i == ADDR_W'(LBIC_MASK_OFS);

  a_r2_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == |($past(irq_i) & mask_q));

  a_r3_vec_vs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vec |-> ((rdata_o != '0) == irq_o));

  a_r3_vec_format: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vec |-> (rdata_o[1:0] == 2'b00 && rdata_o <= DATA_W'((N_SRC + 1) * 4)));

  a_r4_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> mask_q == $past(wdata_i[N_SRC-1:0]));

  a_r6_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));

  a_r4_mask_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mask |-> rdata_o == DATA_W'(mask_q));

  a_r6_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_other |-> rdata_o == '0);

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> rdata_o == '0);

  // R5: reset values hold while reset is applied
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r5_reset_vals: assert (mask_q == MASK_RST && irq_o == 1'b0);
    end
  end
endmodule

bind lbic_top lbic_top_chk #(
  .N_SRC    (N_SRC),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .MASK_RST (MASK_RST)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_i   (irq_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .mask_q  (mask_q)
);

// File: tb/lbic_top_bench.sv
module lbic_top_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 10;

  typedef struct packed {
    logic [15:0] lvl;
    logic        wr;
    logic [15:0] mask;
    logic [15:0] vec;
    logic        out;
  } step_t;

  // R2 R3 R4: levels, optional mask write in the same cycle, expected vector and output
  localparam step_t TBL [NV] = '{
    '{16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{16'h0010, 1'b0, 16'h0000, 16'h0014, 1'b1},
    '{16'h0001, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{16'h0001, 1'b1, 16'hFFFF, 16'h0004, 1'b1},
    '{16'h8000, 1'b0, 16'h0000, 16'h0040, 1'b1},
    '{16'h8421, 1'b0, 16'h0000, 16'h0004, 1'b1},
    '{16'h8420, 1'b0, 16'h0000, 16'h0018, 1'b1},
    '{16'h8420, 1'b1, 16'h8000, 16'h0040, 1'b1},
    '{16'hFFFF, 1'b1, 16'h0000, 16'h0000, 1'b0},
    '{16'h0C00, 1'b1, 16'h0F00, 16'h002C, 1'b1}
  };

  logic        clk_i  = 1'b0;
  logic        rst_ni = 1'b1;
  logic [15:0] irq_i  = '0;
  logic        req_i  = 1'b0;
  logic        we_i   = 1'b0;
  logic [11:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] cur_mask;
  logic [15:0] rd;

  always #(CLK_P / 2) clk_i = ~clk_i;

  lbic_top u_lbic_top (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a falling edge; finishes before the next rising edge
  task automatic bus_rd(input logic [11:0] a, output logic [15:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    // R5 reset state
    check("R5 irq_o in reset", {15'd0, irq_o}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    bus_rd(12'h002, rd); check("R5 mask reset", rd, 16'h0010);
    bus_rd(12'h000, rd); check("R5 vector reset", rd, 16'h0000);
    cur_mask = 16'h0010;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      irq_i = TBL[i].lvl;
      if (TBL[i].wr) begin
        req_i = 1'b1; we_i = 1'b1; addr_i = 12'h002; wdata_i = TBL[i].mask;
        cur_mask = TBL[i].mask;
      end
      @(posedge clk_i);
      @(negedge clk_i);
      req_i = 1'b0; we_i = 1'b0;
      check("R2 irq_o table", {15'd0, irq_o}, {15'd0, TBL[i].out});
      bus_rd(12'h000, rd); check("R3 vector table", rd, TBL[i].vec);
      bus_rd(12'h002, rd); check("R4 mask readback", rd, cur_mask);
    end

    // R7: latency of exactly one edge on input change
    bus_wr(12'h002, 16'h0004);
    irq_i = 16'h0000;
    @(posedge clk_i); @(negedge clk_i);
    check("R7 irq_o low before", {15'd0, irq_o}, 16'h0000);
    irq_i = 16'h0004;
    #1 check("R7 irq_o unchanged before edge", {15'd0, irq_o}, 16'h0000);
    @(posedge clk_i); #1;
    check("R7 irq_o after edge", {15'd0, irq_o}, 16'h0001);
    @(negedge clk_i);

    // R8: repeated vector reads have no side effect
    bus_rd(12'h000, rd); check("R8 first read", rd, 16'h000C);
    @(negedge clk_i);
    bus_rd(12'h000, rd); check("R8 second read", rd, 16'h000C);
    check("R8 irq_o kept", {15'd0, irq_o}, 16'h0001);

    // R9: no read strobe means zero data
    #1 check("R9 idle rdata", rdata_o, 16'h0000);

    // R6: unmapped offsets and writes to the vector offset
    bus_rd(12'h004, rd); check("R6 unmapped read", rd, 16'h0000);
    bus_rd(12'h001, rd); check("R6 odd offset read", rd, 16'h0000);
    bus_wr(12'h004, 16'h0000);
    bus_rd(12'h002, rd); check("R6 mask after unmapped write", rd, 16'h0004);
    bus_wr(12'h000, 16'h0000);
    bus_rd(12'h002, rd); check("R6 mask after vector write", rd, 16'h0004);
    check("R6 irq_o after ignored writes", {15'd0, irq_o}, 16'h0001);

    // R7: mask write drops irq_o on the write edge, not before
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 12'h002; wdata_i = 16'h0000;
    #1 check("R9 rdata during write", rdata_o, 16'h0000);
    check("R7 irq_o before mask edge", {15'd0, irq_o}, 16'h0001);
    @(posedge clk_i); #1;
    check("R4 irq_o after mask clear", {15'd0, irq_o}, 16'h0000);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;

    // R1: source follows level down
    bus_wr(12'h002, 16'h0100);
    irq_i = 16'h0100;
    @(posedge clk_i); @(negedge clk_i);
    bus_rd(12'h000, rd); check("R1 line 8 active", rd, 16'h0024);
    irq_i = 16'h0000;
    @(posedge clk_i); @(negedge clk_i);
    bus_rd(12'h000, rd); check("R1 line 8 dropped", rd, 16'h0000);
    check("R1 irq_o dropped", {15'd0, irq_o}, 16'h0000);

    // R5: reset mid-run restores mask
    bus_wr(12'h002, 16'hFFFF);
    irq_i = 16'h0001;
    @(posedge clk_i); @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R5 irq_o async reset", {15'd0, irq_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    irq_i = 16'h0000;
    @(negedge clk_i);
    bus_rd(12'h002, rd); check("R5 mask after reset", rd, 16'h0010);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule